// File: doc/BRIEF.md
# Parallel-Nonce Double SHA-256 Header Hasher

This block takes a 19-word block header from a word-wide memory, appends each candidate nonce of a batch, and computes the double SHA-256 digest for every nonce at once. The header and nonce together span two 512-bit message blocks. The first block is the same for every nonce, so the block compresses it only once. Every nonce's second-block compression then starts from that saved midstate. The 256-bit result is hashed a second time from the standard initial value. The first digest word of each final hash is written back to memory, one word per nonce.

A host places the header at `hdr_base` and pulses `start`. A six-state controller then steps through its states in a fixed order:
- IDLE waits for `start` and holds the initial hash constants on the engines.
- READ fetches the header.
- COMP1B compresses the shared first block on engine 0.
- COMP2B compresses the per-nonce second blocks on all engines in lock-step.
- HASHFIN runs the second hash.
- WRITE stores the results starting at `res_base`.

The transitions are IDLE→READ on `start`, READ→COMP1B after the last header word is captured, COMP1B→COMP2B→HASHFIN after the finalising cycle of each phase, WRITE→IDLE after the last result write, and any illegal code→IDLE. `done` pulses for one cycle when the controller is back in IDLE.

Top module: `dsha_nonce_hasher`

## Requirements
- R1: After reset, `done` and `mem_we` are 0 and the block waits in IDLE until `start` is sampled high.
- R2: In the cycle after the edge that samples `start`, the block presents address `hdr_base`. It then presents `hdr_base`+1 through `hdr_base`+18, one per cycle. Read data is captured one cycle after its address.
- R3: The message for nonce k (k = 0 .. NONCES-1) is header words 0..18, then the 32-bit value k as word 19, then 0x80000000, then ten zero words, then the length word 640. Words are big-endian SHA-256 message words.
- R4: The word written for nonce k is digest word 0 (the most significant) of SHA-256 applied to the 256-bit SHA-256 digest of the R3 message. It is written to `res_base`+k, and the writes go in increasing k order on consecutive cycles.
- R5: A run issues exactly NONCES memory writes, and all of them fall in `res_base` .. `res_base`+NONCES-1.
- R6: `done` is high for exactly one cycle, in the cycle right after the last write, and the block is then idle.
- R7: With NONCES=16, `done` rises after the 234th rising edge that follows the edge sampling `start`.
- R8: `start` has no effect while a run is in progress. Holding it high for a whole run leaves both the timing and the results unchanged.
- R9: Read data is ignored outside READ. Changing the header in memory after READ does not change the written results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Word address for reads and writes |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data (digest word 0 of a nonce) |
| mem_rdata | input | 32 | Read data, valid one cycle after its address |
| hdr_base | input | AW | Address of header word 0 |
| res_base | input | AW | Address of the result for nonce 0 |

## Verification
The bench builds the block with the default batch of NONCES=16 and with AW=10. A 1024-word memory model can then hold the header and the result area at arbitrary, non-overlapping bases. The full batch brings the fixed 234-edge latency within reach, along with the nonce range 0 to 15 and the result addresses at both ends of the window. Headers of all zeros, all ones and random words are compared against a reference double hash written in the bench. One run rewrites the header during compression, and another keeps `start` high for the whole run.

// File: rtl/dsha_pkg.sv
package dsha_pkg;

    typedef logic [0:7][31:0]  hv_t;
    typedef logic [0:15][31:0] blk_t;

    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_COMP1B, S_COMP2B, S_HASHFIN, S_WRITE
    } state_e;

    localparam hv_t IV = {
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
    };

    localparam logic [0:63][31:0] K_TAB = {
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic logic [31:0] rotr(input logic [31:0] x, input int unsigned n);
        return (x >> n) | (x << (32 - n));
    endfunction

endpackage

// File: rtl/dsha_round.sv
module dsha_round
    import dsha_pkg::*;
(
    input  hv_t         s,
    input  logic [31:0] kw,
    output hv_t         n
);
    logic [31:0] big1, choose, big0, major, t1, t2;

    always_comb begin
        big1   = rotr(s[4], 6) ^ rotr(s[4], 11) ^ rotr(s[4], 25);
        choose = (s[4] & s[5]) ^ (~s[4] & s[6]);
        big0   = rotr(s[0], 2) ^ rotr(s[0], 13) ^ rotr(s[0], 22);
        major  = (s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]);
        t1     = s[7] + big1 + choose + kw;
        t2     = big0 + major;
        n      = {t1 + t2, s[0], s[1], s[2], s[3] + t1, s[4], s[5], s[6]};
    end
endmodule

// File: rtl/dsha_expand.sv
module dsha_expand
    import dsha_pkg::*;
(
    input  logic [31:0] w0,
    input  logic [31:0] w1,
    input  logic [31:0] w9,
    input  logic [31:0] w14,
    output logic [31:0] wn
);
    logic [31:0] sm0, sm1;

    always_comb begin
        sm0 = rotr(w1, 7) ^ rotr(w1, 18) ^ (w1 >> 3);
        sm1 = rotr(w14, 17) ^ rotr(w14, 19) ^ (w14 >> 10);
        wn  = sm1 + w9 + sm0 + w0;
    end
endmodule

// File: rtl/dsha_lane.sv
module dsha_lane
    import dsha_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic       go,
    input  logic       fin,
    input  logic [5:0] kt,
    input  hv_t        init_h,
    input  blk_t       blk,
    output hv_t        dig
);
    hv_t         st, hs, st_n;
    blk_t        w;
    logic [31:0] wn;

    dsha_round u_rnd (
        .s  (st),
        .kw (K_TAB[kt] + w[0]),
        .n  (st_n)
    );

    dsha_expand u_exp (
        .w0  (w[0]),
        .w1  (w[1]),
        .w9  (w[9]),
        .w14 (w[14]),
        .wn  (wn)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= '0;
            hs  <= '0;
            w   <= '0;
            dig <= '0;
        end else begin
            if (ld) begin
                st <= init_h;
                hs <= init_h;
                w  <= blk;
            end else if (go) begin
                st <= st_n;
                w  <= {w[1:15], wn};
            end
            if (fin) begin
                for (int i = 0; i < 8; i++) begin
                    dig[i] <= hs[i] + st[i];
                end
            end
        end
    end

    AST_LD_GO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld && go)); // R3
    AST_DIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(dig)); // R9
endmodule

// File: rtl/dsha_nonce_hasher.sv
module dsha_nonce_hasher
    import dsha_pkg::*;
#(
    parameter int NONCES = 16,
    parameter int AW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic [AW-1:0] hdr_base,
    input  logic [AW-1:0] res_base
);
    localparam int HDR_N = 19;
    localparam int RND_N = 64;
    localparam int CW    = 7;
    localparam int HI_W  = $clog2(HDR_N);
    localparam int LI_W  = (NONCES > 1) ? $clog2(NONCES) : 1;
    localparam logic [CW-1:0] C_RD_END = CW'(HDR_N);
    localparam logic [CW-1:0] C_FIN    = CW'(RND_N + 1);
    localparam logic [CW-1:0] C_WR_END = CW'(NONCES - 1);

    state_e          state;
    logic [CW-1:0]   cnt;
    logic            done_q;
    logic [31:0]     hdr [HDR_N];
    hv_t             dig_a [NONCES];
    logic            ph_ld, ph_go, ph_fin;
    logic [5:0]      kt;
    logic [HI_W-1:0] hidx;
    logic [LI_W-1:0] lsel;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    cnt <= '0;
                    if (start) state <= S_READ;
                end
                S_READ: begin
                    if (cnt == C_RD_END) begin
                        state <= S_COMP1B;
                        cnt   <= '0;
                    end else cnt <= cnt + CW'(1);
                end
                S_COMP1B, S_COMP2B, S_HASHFIN: begin
                    if (cnt == C_FIN) begin
                        cnt <= '0;
                        if (state == S_COMP1B)      state <= S_COMP2B;
                        else if (state == S_COMP2B) state <= S_HASHFIN;
                        else                        state <= S_WRITE;
                    end else cnt <= cnt + CW'(1);
                end
                S_WRITE: begin
                    if (cnt == C_WR_END) begin
                        state  <= S_IDLE;
                        cnt    <= '0;
                        done_q <= 1'b1;
                    end else cnt <= cnt + CW'(1);
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // header capture, one cycle behind the address
    assign hidx = HI_W'(cnt - CW'(1));
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HDR_N; i++) hdr[i] <= '0;
        end else if (state == S_READ && cnt != '0) begin
            hdr[hidx] <= mem_rdata;
        end
    end

    // outputs and phase controls
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        ph_ld     = 1'b0;
        ph_go     = 1'b0;
        ph_fin    = 1'b0;
        kt        = 6'(cnt - CW'(1));
        lsel      = LI_W'(cnt);
        unique case (state)
            S_READ: mem_addr = hdr_base + AW'(cnt);
            S_COMP1B, S_COMP2B, S_HASHFIN: begin
                ph_ld  = (cnt == '0);
                ph_go  = (cnt != '0) && (cnt != C_FIN);
                ph_fin = (cnt == C_FIN);
            end
            S_WRITE: begin
                mem_we    = 1'b1;
                mem_addr  = res_base + AW'(cnt);
                mem_wdata = dig_a[lsel][0];
            end
            default: ;
        endcase
    end

    assign done = done_q;

    for (genvar k = 0; k < NONCES; k++) begin : g_lane
        localparam bit IS_FIRST = (k == 0);
        hv_t  ih;
        blk_t bk;
        logic en;

        assign en = IS_FIRST || (state != S_COMP1B);

        always_comb begin
            unique case (state)
                S_COMP2B: begin
                    ih = dig_a[0];
                    bk = {hdr[16], hdr[17], hdr[18], 32'(k), 32'h8000_0000, 320'd0, 32'd640};
                end
                S_HASHFIN: begin
                    ih = IV;
                    bk = {dig_a[k], 32'h8000_0000, 192'd0, 32'd256};
                end
                default: begin
                    ih = IV;
                    bk = {hdr[0], hdr[1], hdr[2], hdr[3], hdr[4], hdr[5], hdr[6], hdr[7],
                          hdr[8], hdr[9], hdr[10], hdr[11], hdr[12], hdr[13], hdr[14], hdr[15]};
                end
            endcase
        end

        dsha_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ph_ld && en),
            .go     (ph_go && en),
            .fin    (ph_fin && en),
            .kt     (kt),
            .init_h (ih),
            .blk    (bk),
            .dig    (dig_a[k])
        );
    end

    AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == S_WRITE)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_we) && !mem_we && state == S_IDLE)); // R6
    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ && cnt != '0 && cnt < C_RD_END) |-> mem_addr == $past(mem_addr) + AW'(1)); // R2
    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + AW'(1)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_WRITE) |=> state != S_IDLE); // R8
endmodule

// File: tb/tb_dsha_nonce_hasher.sv
`timescale 1ns/1ps
module tb_dsha_nonce_hasher;
    localparam int NN = 16;
    localparam int AWB = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           done;
    logic [AWB-1:0] mem_addr;
    logic           mem_we;
    logic [31:0]    mem_wdata;
    logic [31:0]    mem_rdata;
    logic [AWB-1:0] hdr_base = '0;
    logic [AWB-1:0] res_base = '0;

    logic [31:0]    mem [1024];
    logic           tb_pw = 1'b0;
    logic [AWB-1:0] tb_pa = '0;
    logic [31:0]    tb_pd = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] hw [19];

    localparam logic [31:0] KB [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };
    localparam logic [255:0] H0 = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                   32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

    dsha_nonce_hasher #(.NONCES(NN), .AW(AWB)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .hdr_base(hdr_base), .res_base(res_base)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else if (tb_pw) mem[tb_pa] <= tb_pd;
    end

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [255:0] ref_comp(input logic [255:0] hin, input logic [511:0] b);
        logic [31:0] w [64];
        logic [31:0] v [8];
        logic [31:0] t1, t2, s0, s1;
        logic [255:0] r;
        for (int i = 0; i < 16; i++) w[i] = b[511 - 32*i -: 32];
        for (int i = 16; i < 64; i++) begin
            s0 = rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3);
            s1 = rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10);
            w[i] = w[i-16] + s0 + w[i-7] + s1;
        end
        for (int i = 0; i < 8; i++) v[i] = hin[255 - 32*i -: 32];
        for (int i = 0; i < 64; i++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KB[i] + w[i];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = hin[255 - 32*i -: 32] + v[i];
        return r;
    endfunction

    // expected word for nonce k, built straight from R3 and R4
    function automatic logic [31:0] ref_word(input logic [31:0] k);
        logic [511:0] b1, b2, b3;
        logic [255:0] mid, d1, d2;
        for (int i = 0; i < 16; i++) b1[511 - 32*i -: 32] = hw[i];
        b2 = {hw[16], hw[17], hw[18], k, 32'h8000_0000, 320'd0, 32'd640};
        mid = ref_comp(H0, b1);
        d1 = ref_comp(mid, b2);
        b3 = {d1, 32'h8000_0000, 192'd0, 32'd256};
        d2 = ref_comp(H0, b3);
        return d2[255:224];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [31:0] d);
        @(negedge clk);
        tb_pw = 1'b1; tb_pa = AWB'(a); tb_pd = d;
        @(negedge clk);
        tb_pw = 1'b0;
    endtask

    task automatic run_case(input int hb, input int rb, input bit hold, input bit scramble);
        logic [31:0] exp_w [NN];
        int wr_addr [NN];
        int wr_n;
        int lat;
        bit addr_ok;
        bit wr_range_ok;
        for (int i = 0; i < 19; i++) poke(hb + i, hw[i]);
        for (int k = 0; k < NN; k++) poke(rb + k, 32'hDEAD_BEEF);
        for (int k = 0; k < NN; k++) exp_w[k] = ref_word(32'(k));
        hdr_base = AWB'(hb);
        res_base = AWB'(rb);
        wr_n = 0; lat = -1; addr_ok = 1'b1; wr_range_ok = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        if (!hold) start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (i < 19 && mem_addr != AWB'(hb + i)) addr_ok = 1'b0;
            if (scramble) begin
                if (i >= 40 && i < 59) begin
                    tb_pw = 1'b1; tb_pa = AWB'(hb + i - 40); tb_pd = $urandom;
                end else tb_pw = 1'b0;
            end
            if (mem_we) begin
                if (wr_n < NN) wr_addr[wr_n] = int'(mem_addr);
                if (int'(mem_addr) < rb || int'(mem_addr) >= rb + NN) wr_range_ok = 1'b0;
                wr_n++;
            end
            if (done) begin
                lat = i;
                start = 1'b0;
                break;
            end
            @(posedge clk);
            #1;
        end
        tb_pw = 1'b0;
        chk(lat >= 0, "R7 watchdog: done never rose", 32'(lat), 32'd234);
        chk(addr_ok, "R2 header read address sequence", 32'(addr_ok), 32'd1);
        chk(lat == 234, "R7 R8 latency from start to done", 32'(lat), 32'd234);
        chk(wr_n == NN, "R5 number of writes", 32'(wr_n), 32'(NN));
        chk(wr_range_ok, "R5 write outside result window", 32'(wr_range_ok), 32'd1);
        for (int k = 0; k < NN && k < wr_n; k++)
            chk(wr_addr[k] == rb + k, "R4 write order", 32'(wr_addr[k]), 32'(rb + k));
        for (int k = 0; k < NN; k++)
            chk(mem[rb + k] == exp_w[k], scramble ? "R9 R3 R4 result word" : "R3 R4 result word",
                mem[rb + k], exp_w[k]);
        @(posedge clk);
        #1;
        chk(done == 1'b0, "R6 done lasts one cycle", 32'(done), 32'd0);
        chk(mem_we == 1'b0, "R6 R8 idle after done", 32'(mem_we), 32'd0);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [511:0] abc;
        logic [255:0] dabc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(done == 1'b0, "R1 done low in reset", 32'(done), 32'd0);
        chk(mem_we == 1'b0, "R1 mem_we low in reset", 32'(mem_we), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        chk(done == 1'b0 && mem_we == 1'b0, "R1 idle without start", {done, mem_we}, 32'd0);

        // reference model sanity on a short known message (supports R4)
        abc = {32'h6162_6380, 448'd0, 32'd24};
        dabc = ref_comp(H0, abc);
        chk(dabc[255:224] == 32'hba7816bf, "R4 bench reference model", dabc[255:224], 32'hba7816bf);

        // directed: all-zero header
        for (int i = 0; i < 19; i++) hw[i] = 32'h0;
        run_case(0, 100, 1'b0, 1'b0);
        // directed: all-ones header, start held through the run
        for (int i = 0; i < 19; i++) hw[i] = 32'hFFFF_FFFF;
        run_case(200, 300, 1'b1, 1'b0);
        // random headers and bases, one with the header rewritten after READ
        for (int r = 0; r < 3; r++) begin
            int hb;
            int rb;
            for (int i = 0; i < 19; i++) hw[i] = $urandom;
            hb = int'($urandom % 400);
            rb = 500 + int'($urandom % 400);
            run_case(hb, rb, r == 2, r == 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule